// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block is the host end of a serial link to an analog-to-digital converter whose transfers are framed by an active-low select line. While `run` is high, it opens a frame at a fixed, programmable interval of system clocks, so that the converter samples at equal spacing. Each frame carries a burst of divided serial clocks. The returned bits are shifted in MSB first. Padding is removed and the converted value is placed right-justified in a result register, together with a single-cycle valid strobe.

A normal frame always has sixteen serial clocks, whatever the converter's resolution. The first four bits are leading padding. Depending on the resolution code, zero, two or four bits at the tail are also padding. On request, the controller issues a frame cut short to eight clocks, which puts the converter to sleep. The next frame is a full-length wake-up frame, and its data is thrown away. The sample period, clock divider and resolution code are captured when a frame opens.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `cs_n` and `sclk` are 1, `result_valid` is 0 and `result` is 0.
- R2: `cs_n` falls on the first rising clock edge at which `run` is sampled high, and again every `sample_period` system cycles while `run` stays high. A `sample_period` of 0 acts as 1. No frame opens while `run` is low, and a start that falls inside an active frame is skipped.
- R3: A normal frame has exactly 16 rising `sclk` edges while `cs_n` is low. Every low and every high `sclk` phase lasts `clk_div` system cycles, with 0 acting as 1. `sclk` is 1 whenever `cs_n` is 1.
- R4: `sdata` is sampled at each rising `sclk` edge, MSB first. Arrivals 1 to 4 are dropped whatever their value. With `res_sel` 2'b00 or 2'b11, arrivals 5 to 16 form `result[11:0]`, with arrival 5 as the MSB.
- R5: With `res_sel` 2'b01, arrivals 5 to 14 form `result[9:0]`. `result[11:10]` is 0, and arrivals 15 and 16 are ignored.
- R6: With `res_sel` 2'b10, arrivals 5 to 12 form `result[7:0]`. `result[11:8]` is 0, and arrivals 13 to 16 are ignored.
- R7: After a normal frame, `result_valid` is high for exactly one system cycle: the first cycle in which `cs_n` is back at 1. `result` shows the new value from that cycle until the next strobe.
- R8: A one-cycle `pd_req` pulse makes the next frame a power-down frame with exactly 8 rising `sclk` edges. It gives no `result_valid`, and `result` is unchanged.
- R9: The frame after a power-down frame is a wake-up frame with 16 rising `sclk` edges. It gives no `result_valid`, and `result` is unchanged. The frame after the wake-up frame is a normal frame again.
- R10: Changes on `res_sel` or `clk_div` while `cs_n` is low do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables periodic frame starts |
| sample_period | input | 16 | System cycles between frame starts |
| clk_div | input | 8 | System cycles per serial clock phase |
| res_sel | input | 2 | Resolution code: 00/11 twelve bits, 01 ten bits, 10 eight bits |
| pd_req | input | 1 | Pulse: the next frame powers the converter down |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, high when idle |
| result | output | 12 | Right-justified conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
A wrong bit counter shows up at the frame boundary. It is visible on `cs_n` as an edge count other than 16 or 8, and the result is mis-shifted by one or more bits. A corrupted latched resolution or divider shows up in the same frame, as a wrong pad mask on `result` or a wrong phase length on `sclk`. A lost sleep or wake flag shows up one frame later, as a strobe where none belongs or a missing strobe. The bench uses words that are nonzero in the padding positions, so a stripping error is visible on `result` at the strobe that ends the frame.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_SLEEP  = 2'd1,
        KIND_WAKE   = 2'd2
    } frame_kind_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SETUP = 2'd1,
        ENG_LOW   = 2'd2,
        ENG_HIGH  = 2'd3
    } eng_state_e;

    typedef struct packed {
        frame_kind_e kind;
        logic [1:0]  res;
    } frame_tag_t;

    // Number of tail padding bits for a resolution code
    function automatic int unsigned trail_bits(input logic [1:0] code,
                                               input int unsigned step);
        case (code)
            2'b01:   return step;
            2'b10:   return 2 * step;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/adc_frame_sched.sv
module adc_frame_sched
    import adc_frame_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    input  logic             pd_req,
    input  logic             eng_idle,
    output logic             start,
    output frame_kind_e      kind
);

    logic [PER_W-1:0] tick_cnt;
    logic             pend_q;
    logic             asleep_q;
    logic             tick;

    assign tick  = run && (tick_cnt == '0);
    assign start = tick && eng_idle;

    always_comb begin
        if (pend_q)        kind = KIND_SLEEP;
        else if (asleep_q) kind = KIND_WAKE;
        else               kind = KIND_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            pend_q   <= 1'b0;
            asleep_q <= 1'b0;
        end else begin
            if (!run)
                tick_cnt <= '0;
            else if (tick_cnt == '0)
                tick_cnt <= (period == '0) ? '0 : period - PER_W'(1);
            else
                tick_cnt <= tick_cnt - PER_W'(1);

            pend_q <= pd_req | (pend_q & ~start);

            if (start) begin
                if (kind == KIND_SLEEP)     asleep_q <= 1'b1;
                else if (kind == KIND_WAKE) asleep_q <= 1'b0;
            end
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        !run |=> (tick_cnt == '0)) else $error("tick counter not cleared"); // R2

endmodule

// File: rtl/adc_serial_engine.sv
module adc_serial_engine
    import adc_frame_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SLEEP_BITS = 8,
    parameter int DIV_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  frame_kind_e           kind,
    input  logic [1:0]            res,
    input  logic [DIV_W-1:0]      half,
    input  logic                  sdata,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  idle,
    output logic                  frame_end,
    output logic [FRAME_BITS-1:0] word,
    output frame_tag_t            tag
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    eng_state_e            state_q;
    logic [DIV_W-1:0]      ph_q;
    logic [DIV_W-1:0]      h_q;
    logic [DIV_W-1:0]      half_eff;
    logic [CNT_W-1:0]      bitcnt_q;
    logic [CNT_W-1:0]      nbits_q;
    frame_tag_t            tag_q;
    logic [FRAME_BITS-1:0] word_q;
    logic                  cs_q;
    logic                  sclk_q;

    assign half_eff  = (half == '0) ? DIV_W'(1) : half;
    assign idle      = (state_q == ENG_IDLE);
    assign frame_end = (state_q == ENG_HIGH) && (ph_q == '0) && (bitcnt_q == nbits_q);
    assign cs_n      = cs_q;
    assign sclk      = sclk_q;
    assign word      = word_q;
    assign tag       = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            ph_q     <= '0;
            h_q      <= DIV_W'(1);
            bitcnt_q <= '0;
            nbits_q  <= CNT_W'(FRAME_BITS);
            tag_q    <= '{kind: KIND_NORMAL, res: 2'b00};
            word_q   <= '0;
            cs_q     <= 1'b1;
            sclk_q   <= 1'b1;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        cs_q     <= 1'b0;
                        sclk_q   <= 1'b1;
                        h_q      <= half_eff;
                        ph_q     <= half_eff - DIV_W'(1);
                        bitcnt_q <= '0;
                        nbits_q  <= (kind == KIND_SLEEP) ? CNT_W'(SLEEP_BITS)
                                                         : CNT_W'(FRAME_BITS);
                        tag_q    <= '{kind: kind, res: res};
                        word_q   <= '0;
                        state_q  <= ENG_SETUP;
                    end
                end
                ENG_SETUP: begin
                    if (ph_q == '0) begin
                        sclk_q  <= 1'b0;
                        ph_q    <= h_q - DIV_W'(1);
                        state_q <= ENG_LOW;
                    end else begin
                        ph_q <= ph_q - DIV_W'(1);
                    end
                end
                ENG_LOW: begin
                    if (ph_q == '0) begin
                        sclk_q   <= 1'b1;
                        word_q   <= {word_q[FRAME_BITS-2:0], sdata};
                        bitcnt_q <= bitcnt_q + CNT_W'(1);
                        ph_q     <= h_q - DIV_W'(1);
                        state_q  <= ENG_HIGH;
                    end else begin
                        ph_q <= ph_q - DIV_W'(1);
                    end
                end
                ENG_HIGH: begin
                    if (ph_q == '0) begin
                        if (bitcnt_q == nbits_q) begin
                            cs_q    <= 1'b1;
                            state_q <= ENG_IDLE;
                        end else begin
                            sclk_q  <= 1'b0;
                            ph_q    <= h_q - DIV_W'(1);
                            state_q <= ENG_LOW;
                        end
                    end else begin
                        ph_q <= ph_q - DIV_W'(1);
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        cs_q |-> sclk_q) else $error("sclk low outside a frame"); // R3
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bitcnt_q <= nbits_q) else $error("bit counter overran frame"); // R3
    AST_CS_FALL_ON_START: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_q) |-> $past(start)) else $error("frame opened without start"); // R2
    AST_SHORT_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        (frame_end && tag_q.kind == KIND_SLEEP) |-> (bitcnt_q == CNT_W'(SLEEP_BITS)))
        else $error("power-down frame length wrong"); // R8

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
    import adc_frame_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int LEAD_BITS  = 4,
    parameter int TRAIL_STEP = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             frame_end,
    input  logic [FRAME_BITS-1:0]            word,
    input  frame_tag_t                       tag,
    output logic [FRAME_BITS-LEAD_BITS-1:0]  result,
    output logic                             valid
);

    localparam int RES_W = FRAME_BITS - LEAD_BITS;

    logic [RES_W-1:0] aligned;
    logic             take;

    assign aligned = word[RES_W-1:0] >> trail_bits(tag.res, TRAIL_STEP);
    assign take    = frame_end && (tag.kind == KIND_NORMAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= take;
            if (take) result <= aligned;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid) else $error("valid longer than a cycle"); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(result)) else $error("result moved without strobe"); // R8
    AST_MID_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (take && tag.res == 2'b01) |=> (result[RES_W-1 -: TRAIL_STEP] == '0))
        else $error("ten-bit result not right-justified"); // R5

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int SLEEP_BITS = 8,
    parameter int LEAD_BITS  = 4,
    parameter int TRAIL_STEP = 2,
    parameter int PER_W      = 16,
    parameter int DIV_W      = 8,
    localparam int RES_W     = FRAME_BITS - LEAD_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PER_W-1:0] sample_period,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [1:0]       res_sel,
    input  logic             pd_req,
    input  logic             sdata,
    output logic             cs_n,
    output logic             sclk,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);

    logic                  start;
    frame_kind_e           kind;
    logic                  eng_idle;
    logic                  frame_end;
    logic [FRAME_BITS-1:0] word;
    frame_tag_t            tag;

    adc_frame_sched #(.PER_W(PER_W)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .period   (sample_period),
        .pd_req   (pd_req),
        .eng_idle (eng_idle),
        .start    (start),
        .kind     (kind)
    );

    adc_serial_engine #(
        .FRAME_BITS (FRAME_BITS),
        .SLEEP_BITS (SLEEP_BITS),
        .DIV_W      (DIV_W)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .kind      (kind),
        .res       (res_sel),
        .half      (clk_div),
        .sdata     (sdata),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .idle      (eng_idle),
        .frame_end (frame_end),
        .word      (word),
        .tag       (tag)
    );

    adc_result_fmt #(
        .FRAME_BITS (FRAME_BITS),
        .LEAD_BITS  (LEAD_BITS),
        .TRAIL_STEP (TRAIL_STEP)
    ) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .word      (word),
        .tag       (tag),
        .result    (result),
        .valid     (result_valid)
    );

    AST_START_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> cs_n) else $error("start during active frame"); // R2
    AST_VALID_ON_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (cs_n && !$past(cs_n))) else $error("strobe off frame end"); // R7

endmodule

// File: tb/tb_adc_frame_ctrl.sv
module tb_adc_frame_ctrl;

    typedef struct {
        int          n;
        int          div;
        bit          v;
        logic [11:0] r;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] sample_period = 16'd120;
    logic [7:0]  clk_div = 8'd1;
    logic [1:0]  res_sel = 2'b00;
    logic        pd_req = 1'b0;
    logic        sdata = 1'b0;
    logic        cs_n;
    logic        sclk;
    logic [11:0] result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    exp_t        expq[$];
    logic [15:0] txq[$];
    logic [15:0] tx_word = '0;
    int          tx_idx = 0;
    bit          model_asleep = 0;
    logic [11:0] last_result = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_frame_ctrl dut (
        .clk(clk), .rst(rst), .run(run), .sample_period(sample_period),
        .clk_div(clk_div), .res_sel(res_sel), .pd_req(pd_req), .sdata(sdata),
        .cs_n(cs_n), .sclk(sclk), .result(result), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: a bit is presented on each falling sclk edge
    always @(negedge cs_n) begin
        tx_word = (txq.size() > 0) ? txq.pop_front() : 16'h0000;
        tx_idx  = 15;
    end
    always @(negedge sclk) begin
        if (cs_n == 1'b0) begin
            sdata <= (tx_idx >= 0) ? tx_word[tx_idx] : 1'b0;
            tx_idx = tx_idx - 1;
        end
    end

    // Monitor / scoreboard
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b1;
    int   rise_cnt = 0;
    int   low_cnt = 0;
    bit   chk_drop = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (chk_drop) begin
                chk(result_valid == 1'b0, "R7", "strobe width", result_valid, 0);
                chk_drop = 0;
            end else if (result_valid && !(prev_cs == 1'b0 && cs_n == 1'b1)) begin
                chk(0, "R7", "stray strobe", 1, 0);
            end
            if (cs_n == 1'b0 && sclk == 1'b0) low_cnt++;
            if (cs_n == 1'b0 && sclk == 1'b1 && prev_sclk == 1'b0) begin
                rise_cnt++;
                if (expq.size() > 0)
                    chk(low_cnt == expq[0].div, "R3", "low phase", low_cnt, expq[0].div);
                low_cnt = 0;
            end
            if (prev_cs == 1'b0 && cs_n == 1'b1) begin
                if (expq.size() == 0) begin
                    chk(0, "R2", "unexpected frame", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(rise_cnt == e.n, e.req, "sclk edges", rise_cnt, e.n);
                    chk(result_valid == e.v, e.req, "strobe", result_valid, e.v);
                    chk(result == e.r, e.req, "result", result, e.r);
                    chk_drop = 1;
                end
                rise_cnt = 0;
                low_cnt  = 0;
            end
            if (cs_n == 1'b1)
                chk_drop = chk_drop; // idle: sclk must stay high (asserted in RTL)
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    function automatic logic [11:0] expect_word(input logic [15:0] w, input logic [1:0] res);
        int n;
        logic [11:0] r;
        n = (res == 2'b01) ? 10 : (res == 2'b10) ? 8 : 12;
        r = '0;
        for (int i = 4; i < 4 + n; i++) r = {r[10:0], w[15 - i]};
        return r;
    endfunction

    function automatic exp_t make_item(input logic [15:0] w, input logic [1:0] res,
                                       input int div, input bit pd, input string req);
        exp_t e;
        e.div = div;
        e.req = req;
        if (pd) begin
            e.n = 8; e.v = 0; e.r = last_result; model_asleep = 1;
        end else if (model_asleep) begin
            e.n = 16; e.v = 0; e.r = last_result; model_asleep = 0;
        end else begin
            e.n = 16; e.v = 1; e.r = expect_word(w, res); last_result = e.r;
        end
        return e;
    endfunction

    task automatic wait_cs(input logic level);
        do @(negedge clk); while (cs_n !== level);
    endtask

    // Driver: one frame, with configuration disturbed mid-frame (R10)
    task automatic one_frame(input logic [15:0] w, input logic [1:0] res,
                             input int div, input bit pd, input string req);
        @(negedge clk);
        res_sel = res;
        clk_div = 8'(div);
        txq.push_back(w);
        expq.push_back(make_item(w, res, div, pd, req));
        if (pd) begin
            pd_req = 1'b1;
            @(negedge clk);
            pd_req = 1'b0;
        end
        run = 1'b1;
        wait_cs(1'b0);
        run = 1'b0;
        res_sel = ~res;
        clk_div = 8'(div + 2);
        wait_cs(1'b1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "lines in reset", {cs_n, sclk}, 3);
        chk(result_valid == 1'b0 && result == '0, "R1", "result in reset", result, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "lines after reset", {cs_n, sclk}, 3);
        chk(result_valid == 1'b0 && result == '0, "R1", "result after reset", result, 0);
        repeat (20) @(negedge clk);
        chk(cs_n == 1'b1, "R2", "no frame while run low", cs_n, 1);

        one_frame(16'hFABC, 2'b00, 1, 0, "R4");
        one_frame(16'h0123, 2'b11, 2, 0, "R4");
        one_frame(16'hF5A7, 2'b01, 1, 0, "R5");
        one_frame(16'h9FFF, 2'b01, 3, 0, "R5");
        one_frame(16'h0FFF, 2'b10, 1, 0, "R6");
        one_frame(16'hA5C3, 2'b10, 2, 0, "R6");
        one_frame(16'h7E81, 2'b00, 3, 0, "R10");
        one_frame(16'h0555, 2'b00, 1, 1, "R8");
        one_frame(16'h0AAA, 2'b00, 1, 0, "R9");
        one_frame(16'h0C3F, 2'b00, 1, 0, "R9");

        // R2: periodic cadence
        begin
            int t[4];
            @(negedge clk);
            res_sel = 2'b00;
            clk_div = 8'd2;
            for (int k = 0; k < 4; k++) begin
                txq.push_back(16'h0100 + 16'(k));
                expq.push_back(make_item(16'h0100 + 16'(k), 2'b00, 2, 0, "R2"));
            end
            run = 1'b1;
            for (int k = 0; k < 4; k++) begin
                wait_cs(1'b0);
                t[k] = cyc;
                if (k == 3) run = 1'b0;
                else wait_cs(1'b1);
            end
            wait_cs(1'b1);
            for (int k = 1; k < 4; k++)
                chk(t[k] - t[k-1] == 120, "R2", "start spacing", t[k] - t[k-1], 120);
            repeat (200) @(negedge clk);
            chk(cs_n == 1'b1, "R2", "no frame after run drop", cs_n, 1);
        end

        chk(expq.size() == 0, "R3", "frames outstanding", expq.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule